// File: doc/BRIEF.md
# Transceiver Power-Up Sequencer

This block brings a network transceiver out of power-off in a fixed and safe order. On a start request it switches on the supply rails one at a time: the core rail first, then the I/O rail, then the line-side analog rail. Each step waits a minimum gap, and it also waits until the previous rail reports power-good. Only when every rail is up does it release the transceiver's active-low reset. It then waits out the transceiver's boot time before it raises a ready flag. That flag is the one signal that lets management-bus initialisation software start talking to the transceiver.

Every delay is a parameter counted in system clock cycles. The integrator sets them from the clock frequency: the gap must cover at least 100 µs, and the boot wait must cover the transceiver's 1 to 5 ms boot time. Power-good inputs are synchronised inside the block, and a parameter can turn the feedback off. If a rail never reports good within a timeout, the sequencer raises a fault and holds the transceiver in reset.

A power-down request pulls reset low first. The rails are then removed one by one in reverse order, and the block returns to idle.

Top module: `phy_pwr_seq`

## Requirements
- R1: After system reset all rail enables are 0, `phy_rst_no` is 0, and `mgmt_ready_o` and `fault_o` are 0.
- R2: A start request sampled in idle sets `rail_en_o[0]` (core) on that same clock edge. Rails are then enabled strictly in index order: bit 0 core, bit 1 I/O, bit 2 line side.
- R3: Rail k+1 is enabled no earlier than `GAP_CYC` cycles after rail k, and not before rail k's power-good has been seen through the two-stage synchroniser. When power-good is already present, the gap is exactly `GAP_CYC` cycles.
- R4: `phy_rst_no` stays 0 from system reset until all rails are enabled. It rises `GAP_CYC` cycles after the last rail is enabled, provided that rail's power-good is present.
- R5: `mgmt_ready_o` rises exactly `BOOT_CYC` cycles after `phy_rst_no` rises.
- R6: `mgmt_ready_o` is 1 only while `phy_rst_no` is 1 and all rails are enabled.
- R7: If a rail's power-good has not been seen `PG_TIMEOUT_CYC` cycles after its enable, `fault_o` rises on that edge. From then on no further rail is enabled, reset stays asserted, and the state holds until a power-down request.
- R8: A power-down request sampled outside idle drives `phy_rst_no` and `mgmt_ready_o` to 0 and clears `fault_o`, all on that edge. The highest enabled rail is then cleared `OFF_GAP_CYC` cycles later, and each lower rail another `OFF_GAP_CYC` cycles after that. The block then returns to idle and accepts a new start.
- R9: A start request has no effect while a sequence is running, while ready, or while faulted.
- R10: A power-down request in idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| start_i | input | 1 | Power-up request, sampled each cycle |
| pwrdn_i | input | 1 | Power-down request, sampled each cycle |
| pgood_i | input | N_RAILS | Asynchronous power-good feedback, one bit per rail |
| rail_en_o | output | N_RAILS | Rail enables, bit 0 switched first |
| phy_rst_no | output | 1 | Active-low transceiver reset |
| mgmt_ready_o | output | 1 | Management access permitted |
| fault_o | output | 1 | Power-good timeout occurred |

## Verification
The assertions take some things for granted about the inputs. A rail's power-good is assumed to fall no later than the cycle in which its enable is removed. The request inputs are assumed to be synchronous to the clock. The gap and boot windows are measured by counters in the checker, timed from the visible rise of each enable, so they hold however long power-good takes to arrive.

The bench keeps within these assumptions. It models each regulator as a power-good that follows its enable after a programmable delay and drops the moment the enable drops. It drives every request at the falling edge for one whole cycle. Stalled feedback is modelled only by holding a rail's power-good low.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_RAMP,
      PS_BOOT,
      PS_READY,
      PS_FAULT,
      PS_DOWN
   } pps_state_e;

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CntTop = '1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= '0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else if (cnt_o != CntTop) begin
         cnt_o <= cnt_o + CNT_W'(1);
      end
   end

endmodule

// File: rtl/pps_pgood_sync.sv
module pps_pgood_sync #(
   parameter int N_RAILS   = 3,
   parameter bit USE_PGOOD = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_RAILS-1:0] pgood_i,
   input  logic [N_RAILS-1:0] rail_en_i,
   output logic [N_RAILS-1:0] pg_o
);

   if (USE_PGOOD) begin : g_sync
      logic [N_RAILS-1:0] meta_q, sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
         end else begin
            meta_q <= pgood_i;
            sync_q <= meta_q;
         end
      end
      assign pg_o = sync_q & rail_en_i;
   end else begin : g_nofb
      logic [N_RAILS-1:0] unused_pg;
      assign unused_pg = pgood_i;
      assign pg_o      = rail_en_i;
   end

endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
   import phy_pwr_seq_pkg::*;
#(
   parameter int N_RAILS        = 3,
   parameter int CNT_W          = 8,
   parameter int GAP_CYC        = 16,
   parameter int PG_TIMEOUT_CYC = 64,
   parameter int BOOT_CYC       = 32,
   parameter int OFF_GAP_CYC    = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               pwrdn_i,
   input  logic [N_RAILS-1:0] pg_i,
   input  logic [CNT_W-1:0]   cnt_i,
   output logic               clr_o,
   output logic [N_RAILS-1:0] rail_en_o,
   output logic               phy_rst_no,
   output logic               ready_o,
   output logic               fault_o
);

   localparam int IDX_W = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
   localparam logic [IDX_W-1:0] LastIdx = IDX_W'(N_RAILS - 1);
   localparam logic [CNT_W-1:0] GapLim  = CNT_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] ToLim   = CNT_W'(PG_TIMEOUT_CYC - 1);
   localparam logic [CNT_W-1:0] BootLim = CNT_W'(BOOT_CYC - 1);
   localparam logic [CNT_W-1:0] OffLim  = CNT_W'(OFF_GAP_CYC - 1);

   pps_state_e         state_q, state_d;
   logic [IDX_W-1:0]   idx_q, idx_d, top_idx;
   logic [N_RAILS-1:0] en_q, en_d;
   logic               rst_q, rst_d, rdy_q, rdy_d, flt_q, flt_d;
   logic               down_req;

   // highest rail still switched on, used while ramping down
   always_comb begin
      top_idx = '0;
      for (int k = 0; k < N_RAILS; k++) begin
         if (en_q[k]) top_idx = IDX_W'(k);
      end
   end

   assign down_req = pwrdn_i && (state_q != PS_IDLE) && (state_q != PS_DOWN);

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      en_d    = en_q;
      rst_d   = rst_q;
      rdy_d   = rdy_q;
      flt_d   = flt_q;
      if (down_req) begin
         state_d = PS_DOWN;
         rst_d   = 1'b0;
         rdy_d   = 1'b0;
         flt_d   = 1'b0;
      end else begin
         case (state_q)
            PS_IDLE: begin
               if (start_i) begin
                  en_d[0] = 1'b1;
                  idx_d   = '0;
                  state_d = PS_RAMP;
               end
            end
            PS_RAMP: begin
               if (pg_i[idx_q] && (cnt_i >= GapLim)) begin
                  if (idx_q == LastIdx) begin
                     rst_d   = 1'b1;
                     state_d = PS_BOOT;
                  end else begin
                     en_d[idx_q + IDX_W'(1)] = 1'b1;
                     idx_d = idx_q + IDX_W'(1);
                  end
               end else if (!pg_i[idx_q] && (cnt_i >= ToLim)) begin
                  flt_d   = 1'b1;
                  state_d = PS_FAULT;
               end
            end
            PS_BOOT: begin
               if (cnt_i >= BootLim) begin
                  rdy_d   = 1'b1;
                  state_d = PS_READY;
               end
            end
            PS_DOWN: begin
               if (en_q == '0) begin
                  state_d = PS_IDLE;
               end else if (cnt_i >= OffLim) begin
                  en_d[top_idx] = 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   // the shared timer restarts on every step of the sequence
   assign clr_o = (state_d != state_q) || (en_d != en_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= PS_IDLE;
         idx_q   <= '0;
         en_q    <= '0;
         rst_q   <= 1'b0;
         rdy_q   <= 1'b0;
         flt_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         en_q    <= en_d;
         rst_q   <= rst_d;
         rdy_q   <= rdy_d;
         flt_q   <= flt_d;
      end
   end

   assign rail_en_o  = en_q;
   assign phy_rst_no = rst_q;
   assign ready_o    = rdy_q;
   assign fault_o    = flt_q;

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
   parameter int N_RAILS        = 3,
   parameter bit USE_PGOOD      = 1'b1,
   parameter int GAP_CYC        = 25000,
   parameter int PG_TIMEOUT_CYC = 250000,
   parameter int BOOT_CYC       = 500000,
   parameter int OFF_GAP_CYC    = 2500
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               pwrdn_i,
   input  logic [N_RAILS-1:0] pgood_i,
   output logic [N_RAILS-1:0] rail_en_o,
   output logic               phy_rst_no,
   output logic               mgmt_ready_o,
   output logic               fault_o
);

   localparam int MaxA  = (GAP_CYC > PG_TIMEOUT_CYC) ? GAP_CYC : PG_TIMEOUT_CYC;
   localparam int MaxB  = (BOOT_CYC > OFF_GAP_CYC) ? BOOT_CYC : OFF_GAP_CYC;
   localparam int MaxC  = (MaxA > MaxB) ? MaxA : MaxB;
   localparam int CNT_W = $clog2(MaxC + 1);

   if (N_RAILS < 2) begin : g_bad_rails
      $error("phy_pwr_seq: at least two rails are required");
   end
   if ((GAP_CYC < 1) || (BOOT_CYC < 1) || (OFF_GAP_CYC < 1)) begin : g_bad_delay
      $error("phy_pwr_seq: delays must be at least one cycle");
   end
   if (PG_TIMEOUT_CYC <= GAP_CYC) begin : g_bad_timeout
      $error("phy_pwr_seq: power-good timeout must exceed the rail gap");
   end

   logic [N_RAILS-1:0] pg_s;
   logic [CNT_W-1:0]   cnt;
   logic               clr;

   pps_pgood_sync #(
      .N_RAILS  (N_RAILS),
      .USE_PGOOD(USE_PGOOD)
   ) u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pgood_i  (pgood_i),
      .rail_en_i(rail_en_o),
      .pg_o     (pg_s)
   );

   pps_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .cnt_o (cnt)
   );

   pps_fsm #(
      .N_RAILS       (N_RAILS),
      .CNT_W         (CNT_W),
      .GAP_CYC       (GAP_CYC),
      .PG_TIMEOUT_CYC(PG_TIMEOUT_CYC),
      .BOOT_CYC      (BOOT_CYC),
      .OFF_GAP_CYC   (OFF_GAP_CYC)
   ) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .pwrdn_i   (pwrdn_i),
      .pg_i      (pg_s),
      .cnt_i     (cnt),
      .clr_o     (clr),
      .rail_en_o (rail_en_o),
      .phy_rst_no(phy_rst_no),
      .ready_o   (mgmt_ready_o),
      .fault_o   (fault_o)
   );

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
   parameter int N_RAILS  = 3,
   parameter int GAP_CYC  = 16,
   parameter int BOOT_CYC = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               pwrdn_i,
   input logic [N_RAILS-1:0] rail_en_o,
   input logic               phy_rst_no,
   input logic               mgmt_ready_o,
   input logic               fault_o
);

   logic [N_RAILS-1:0] en_prev;
   logic               rst_prev;
   logic [31:0]        rail_age, rst_age;
   logic               any_rise;

   assign any_rise = |(rail_en_o & ~en_prev);

   // ages count cycles since the most recent visible rise
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_prev  <= '0;
         rst_prev <= 1'b0;
         rail_age <= '0;
         rst_age  <= '0;
      end else begin
         en_prev  <= rail_en_o;
         rst_prev <= phy_rst_no;
         if (any_rise)                rail_age <= 32'd1;
         else if (rail_age != '1)     rail_age <= rail_age + 32'd1;
         if (phy_rst_no && !rst_prev) rst_age <= 32'd1;
         else if (!phy_rst_no)        rst_age <= '0;
         else if (rst_age != '1)      rst_age <= rst_age + 32'd1;
      end
   end

   for (genvar k = 1; k < N_RAILS; k++) begin : g_up
      // R2: a rail comes up only above an already enabled one
      assert_rail_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(rail_en_o[k]) |-> rail_en_o[k-1]);
      // R3: minimum gap since the previous rail came up
      assert_rail_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(rail_en_o[k]) |-> (rail_age >= 32'(GAP_CYC)));
   end

   for (genvar k = 0; k < N_RAILS - 1; k++) begin : g_dn
      // R8: removal runs from the top rail downwards
      assert_reverse_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(rail_en_o[k]) |-> !rail_en_o[k+1]);
   end

   for (genvar k = 0; k < N_RAILS; k++) begin : g_rst_first
      // R8: reset is already asserted when any rail goes away
      assert_reset_before_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(rail_en_o[k]) |-> !$past(phy_rst_no));
   end

   // R4: reset released only with every rail on and after the gap
   assert_reset_needs_rails_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phy_rst_no |-> (&rail_en_o));
   assert_reset_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phy_rst_no) |-> (rail_age >= 32'(GAP_CYC)));

   // R5: boot wait precedes ready
   assert_boot_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mgmt_ready_o) |-> (rst_age >= 32'(BOOT_CYC)));

   // R6: ready implies a released transceiver
   assert_ready_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mgmt_ready_o |-> (phy_rst_no && (&rail_en_o)));

   // R7: a fault keeps the transceiver in reset
   assert_fault_holds_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> (!phy_rst_no && !mgmt_ready_o));

   // R8: ready and reset drop on the edge that takes the request
   assert_pwrdn_drops_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwrdn_i && mgmt_ready_o) |=> (!mgmt_ready_o && !phy_rst_no));

endmodule

bind phy_pwr_seq pps_checker #(
   .N_RAILS (N_RAILS),
   .GAP_CYC (GAP_CYC),
   .BOOT_CYC(BOOT_CYC)
) u_pps_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .pwrdn_i     (pwrdn_i),
   .rail_en_o   (rail_en_o),
   .phy_rst_no  (phy_rst_no),
   .mgmt_ready_o(mgmt_ready_o),
   .fault_o     (fault_o)
);

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;

   localparam int NR   = 3;
   localparam int GAP  = 20;
   localparam int TO   = 60;
   localparam int BOOT = 40;
   localparam int OFF  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          pwrdn = 1'b0;
   logic [NR-1:0] pgood = '0;
   logic [NR-1:0] rail_en;
   logic          phy_rst_n, ready, fault;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   int pg_dly[NR];
   bit pg_block[NR];
   int pg_cnt[NR];

   int rise_en[NR], fall_en[NR];
   int rise_rst, fall_rst, rise_rdy, fall_rdy, rise_flt, fall_flt;
   logic [NR-1:0] p_en = '0;
   logic p_rst = 1'b0, p_rdy = 1'b0, p_flt = 1'b0;

   phy_pwr_seq #(
      .N_RAILS       (NR),
      .USE_PGOOD     (1'b1),
      .GAP_CYC       (GAP),
      .PG_TIMEOUT_CYC(TO),
      .BOOT_CYC      (BOOT),
      .OFF_GAP_CYC   (OFF)
   ) dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .pwrdn_i     (pwrdn),
      .pgood_i     (pgood),
      .rail_en_o   (rail_en),
      .phy_rst_no  (phy_rst_n),
      .mgmt_ready_o(ready),
      .fault_o     (fault)
   );

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // regulator model: power-good follows enable after a delay
   always @(negedge clk) begin
      for (int k = 0; k < NR; k++) begin
         if (!rail_en[k]) pg_cnt[k] = 0;
         else             pg_cnt[k] = pg_cnt[k] + 1;
         pgood[k] = rail_en[k] && !pg_block[k] && (pg_cnt[k] >= pg_dly[k]);
      end
   end

   // edge stamp monitor
   always @(negedge clk) begin
      for (int k = 0; k < NR; k++) begin
         if (rail_en[k] && !p_en[k]) rise_en[k] = cyc;
         if (!rail_en[k] && p_en[k]) fall_en[k] = cyc;
      end
      if (phy_rst_n && !p_rst) rise_rst = cyc;
      if (!phy_rst_n && p_rst) fall_rst = cyc;
      if (ready && !p_rdy) rise_rdy = cyc;
      if (!ready && p_rdy) fall_rdy = cyc;
      if (fault && !p_flt) rise_flt = cyc;
      if (!fault && p_flt) fall_flt = cyc;
      p_en = rail_en; p_rst = phy_rst_n; p_rdy = ready; p_flt = fault;
   end

   task automatic clear_stamps();
      for (int k = 0; k < NR; k++) begin
         rise_en[k] = -1;
         fall_en[k] = -1;
      end
      rise_rst = -1; fall_rst = -1; rise_rdy = -1;
      fall_rdy = -1; rise_flt = -1; fall_flt = -1;
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_pwrdn();
      pwrdn = 1'b1;
      @(negedge clk);
      pwrdn = 1'b0;
   endtask

   // R1: outputs after system reset
   task automatic t_reset_state();
      wait_cyc(3);
      chk("R1 rails", int'(rail_en), 0);
      chk("R1 reset", int'(phy_rst_n), 0);
      chk("R1 ready", int'(ready), 0);
      chk("R1 fault", int'(fault), 0);
   endtask

   // R2 R3 R4 R5, with R9 start pokes in the middle when poke is set
   task automatic t_full_up(bit poke);
      int c;
      clear_stamps();
      c = cyc;
      pulse_start();
      if (poke) begin
         wait_cyc(9);
         pulse_start();
         wait_cyc(59);
         pulse_start();
         wait_cyc(40);
      end else begin
         wait_cyc(110);
      end
      chk("R2 core rail on", rise_en[0], c + 1);
      chk("R3 io rail gap", rise_en[1], c + 1 + GAP);
      chk("R3 line rail gap", rise_en[2], c + 1 + 2 * GAP);
      chk("R4 reset release", rise_rst, c + 1 + 3 * GAP);
      chk("R5 ready after boot", rise_rdy, c + 1 + 3 * GAP + BOOT);
      chk("R6 ready level", int'(ready && phy_rst_n && (&rail_en)), 1);
      chk("R7 no fault", int'(fault), 0);
      if (poke) chk("R9 start mid-sequence ignored", int'(rail_en), 7);
   endtask

   // R9: start while ready changes nothing
   task automatic t_start_in_ready();
      clear_stamps();
      pulse_start();
      wait_cyc(30);
      chk("R9 ready kept", int'(ready), 1);
      chk("R9 reset kept", int'(phy_rst_n), 1);
      chk("R9 rails kept", int'(rail_en), 7);
      chk("R9 no rail fell", fall_en[0] + fall_en[1] + fall_en[2], -3);
   endtask

   // R8: full power-down from ready
   task automatic t_pwrdn_from_ready();
      int c;
      clear_stamps();
      c = cyc;
      pulse_pwrdn();
      wait_cyc(40);
      chk("R8 ready drop", fall_rdy, c + 1);
      chk("R8 reset drop", fall_rst, c + 1);
      chk("R8 line rail off", fall_en[2], c + 1 + OFF);
      chk("R8 io rail off", fall_en[1], c + 1 + 2 * OFF);
      chk("R8 core rail off", fall_en[0], c + 1 + 3 * OFF);
      chk("R8 all off", int'(rail_en), 0);
   endtask

   // R10: power-down in idle does nothing
   task automatic t_pwrdn_idle();
      clear_stamps();
      pulse_pwrdn();
      wait_cyc(10);
      chk("R10 rails stay off", int'(rail_en), 0);
      chk("R10 reset stays low", int'(phy_rst_n), 0);
      chk("R10 fault stays low", int'(fault), 0);
   endtask

   // R3: slow power-good on the io rail stretches the gap
   task automatic t_slow_pgood();
      int c, d;
      clear_stamps();
      pg_dly[1] = 30;
      c = cyc;
      pulse_start();
      wait_cyc(160);
      d = rise_en[2] - rise_en[1];
      chk("R3 io rail on time", rise_en[1], c + 1 + GAP);
      chk("R3 line waits for pgood", int'(d >= 30 && d <= 36), 1);
      if (!(d >= 30 && d <= 36)) $display("  R3 gap was %0d", d);
      chk("R4 reset after line gap", rise_rst, rise_en[2] + GAP);
      chk("R5 ready after boot", rise_rdy, rise_rst + BOOT);
      pulse_pwrdn();
      wait_cyc(40);
      pg_dly[1] = 3;
   endtask

   // R7 R9 R8: timeout, start ignored in fault, then power-down
   task automatic t_timeout();
      int c;
      clear_stamps();
      pg_block[1] = 1'b1;
      c = cyc;
      pulse_start();
      wait_cyc(100);
      chk("R7 fault time", rise_flt, c + 1 + GAP + TO);
      chk("R7 line rail held off", rise_en[2], -1);
      chk("R7 reset held", int'(phy_rst_n), 0);
      chk("R7 no ready", int'(ready), 0);
      pulse_start();
      wait_cyc(10);
      chk("R9 start in fault ignored", int'(rail_en), 3);
      chk("R7 fault held", int'(fault), 1);
      c = cyc;
      pulse_pwrdn();
      wait_cyc(30);
      chk("R8 fault cleared", fall_flt, c + 1);
      chk("R8 io rail off first", fall_en[1], c + 1 + OFF);
      chk("R8 core rail off", fall_en[0], c + 1 + 2 * OFF);
      pg_block[1] = 1'b0;
   endtask

   initial begin
      for (int k = 0; k < NR; k++) begin
         pg_dly[k]   = 3;
         pg_block[k] = 1'b0;
         pg_cnt[k]   = 0;
      end
      clear_stamps();
      wait_cyc(2);
      t_reset_state();
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset_state();
      t_pwrdn_idle();
      t_full_up(1'b1);
      t_start_in_ready();
      t_pwrdn_from_ready();
      t_full_up(1'b0);
      t_pwrdn_from_ready();
      t_slow_pgood();
      t_timeout();
      t_full_up(1'b0);
      t_pwrdn_from_ready();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      wait_cyc(20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule